// File: doc/BRIEF.md
# Timer Clock Prescale and Select Tree

This block makes the count-enable strobes for a five-channel timer. It does not count or compare. It only decides, for each channel, in which system-clock cycles that channel may advance. Two shared 8-bit prescalers divide the system clock. Channels 0 and 1 draw from the first prescaler, and channels 2, 3 and 4 draw from the second. Each channel then divides its group's prescaled tick by a power of two, or ignores it and follows an external clock pin instead. Channels 0 and 1 use external pin 0, and channels 2 to 4 use external pin 1. The external pins are synchronized and reduced to one strobe per rising edge.

Configuration uses a plain single-cycle write port with two registers. Register 0 holds both prescale values. Register 1 holds a 4-bit select field per channel. Every output is a one-cycle strobe in the system clock domain, suitable as a counter enable. There is no data stream and no back-pressure: the strobes are not held for a consumer, so a consumer that is not sampling simply misses them.

Top module: `timer_tick_tree`

## Requirements
- R1: Prescale register (`cfg_addr`=0): bits [7:0] set value N0 and bits [15:8] set value N1. Each prescaler emits one tick every N+1 system cycles, so the ratio ranges from 1 to 256.
- R2: Channels 0 and 1 use prescaler 0 (N0). Channels 2, 3 and 4 use prescaler 1 (N1).
- R3: Select register (`cfg_addr`=1): channel c uses bits [4c+3:4c]. Codes 0, 1, 2 and 3 divide the group's prescaled tick by 2, 4, 8 and 16.
- R4: Select codes 5 to 15 behave as divide-by-16.
- R5: Select code 4 makes the channel follow an external pin: pin 0 for channels 0–1 and pin 1 for channels 2–4. A level first captured high at a clock edge A, after being low, gives one strobe in the cycle after edge A+1. A falling edge gives no strobe.
- R6: Every output strobe lasts exactly one system cycle.
- R7: A write to either register restarts all channel dividers. A write to register 0 also restarts both prescalers. After the write edge to register 0, a divided channel strobes in cycle k (cycle 0 follows the write edge) exactly when (k+1) is a multiple of R·(N+1), where R is the divide ratio.
- R8: Reset clears both registers, giving prescale ratio 1 and divide-by-2 on every channel. Outputs are low during reset. Counting samples from the falling clock edge at which reset is released as sample 0, strobes appear on odd samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = prescale register, 1 = select register |
| cfg_wdata | input | 32 | Write data |
| ext_clk_i | input | 2 | Asynchronous external clock pins (pin 0 for group 0, pin 1 for group 1) |
| tick_o | output | 5 | Per-channel one-cycle count-enable strobes |

## Verification
The hardest case to reach from the ports is a configuration where the two prescaler groups run at different rates while some channels follow external pins and others divide, all in the same window. Only then does sharing a prescaler between the wrong channels, or routing the wrong external pin, show up as a shift in strobe timing. The stimulus therefore reprograms both registers while the previous configuration is still counting, which also exercises restart. It then toggles both external pins at different periods inside the checking loop. Each sampled cycle is compared against a closed-form schedule for every channel.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  // register selector on the configuration port
  typedef enum logic [0:0] {
    REG_PRESCALE = 1'b0,
    REG_CHANSEL  = 1'b1
  } ttt_reg_e;

  localparam int NUM_GROUPS = 2;
endpackage

// File: rtl/ttt_prescaler.sv
module ttt_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [PS_W-1:0] limit,
  output logic            tick
);
  logic [PS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart || cnt_q == limit)  cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == limit);

  // R1
  ps_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
  // R7
  ps_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R1
  ps_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
endmodule

// File: rtl/ttt_ext_edge.sv
module ttt_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign tick = sync_q[SYNC_STAGES-1] & ~last_q;

  // R6
  ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ttt_chan_sel.sv
module ttt_chan_sel #(
  parameter int SEL_W    = 4,
  parameter int LOG2_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pre_tick,
  input  logic             ext_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(LOG2_MAX);

  logic                use_ext;
  logic [LOG2_MAX-1:0] term;
  logic [LOG2_MAX-1:0] dcnt_q;
  logic                div_tick;

  assign use_ext = (sel == EXT_CODE);

  // terminal count: code c gives 2^(c+1)-1, larger codes saturate
  always_comb begin
    term = '0;
    for (int b = 0; b < LOG2_MAX; b++)
      if (b <= int'(sel)) term[b] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dcnt_q <= '0;
    else if (restart)  dcnt_q <= '0;
    else if (pre_tick) dcnt_q <= (dcnt_q == term) ? '0 : dcnt_q + 1'b1;
  end

  assign div_tick = pre_tick && (dcnt_q == term);
  assign tick     = use_ext ? ext_tick : div_tick;

  // R3
  ch_div_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext && tick) |-> pre_tick);
  // R4
  ch_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= term);
  // R7
  ch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (dcnt_q == '0));
endmodule

// File: rtl/timer_tick_tree.sv
module timer_tick_tree #(
  parameter int DATA_W   = 32,
  parameter int NUM_CH   = 5,
  parameter int GRP0_CH  = 2,
  parameter int PS_W     = 8,
  parameter int SEL_W    = 4,
  parameter int LOG2_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [1:0]        ext_clk_i,
  output logic [NUM_CH-1:0] tick_o
);
  import ttt_pkg::*;

  localparam int PS_BITS  = NUM_GROUPS * PS_W;
  localparam int SEL_BITS = NUM_CH * SEL_W;

  logic [PS_BITS-1:0]    ps_q;
  logic [SEL_BITS-1:0]   sel_q;
  logic                  ps_wr;
  logic                  any_wr;
  logic [NUM_GROUPS-1:0] pre_tick;
  logic [NUM_GROUPS-1:0] ext_tick;

  assign any_wr = cfg_we;
  assign ps_wr  = cfg_we && (ttt_reg_e'(cfg_addr) == REG_PRESCALE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      sel_q <= '0;
    end else if (cfg_we) begin
      if (ttt_reg_e'(cfg_addr) == REG_PRESCALE) ps_q  <= cfg_wdata[PS_BITS-1:0];
      else                                      sel_q <= cfg_wdata[SEL_BITS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    ttt_prescaler #(.PS_W(PS_W)) u_ps (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ps_wr),
      .limit   (ps_q[g*PS_W +: PS_W]),
      .tick    (pre_tick[g])
    );
    ttt_ext_edge #(.SYNC_STAGES(2)) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_clk_i[g]),
      .tick     (ext_tick[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = (c < GRP0_CH) ? 0 : 1;
    ttt_chan_sel #(.SEL_W(SEL_W), .LOG2_MAX(LOG2_MAX)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (any_wr),
      .pre_tick (pre_tick[GRP]),
      .ext_tick (ext_tick[GRP]),
      .sel      (sel_q[c*SEL_W +: SEL_W]),
      .tick     (tick_o[c])
    );
  end

  // R8
  top_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tick_o == '0));
endmodule

// File: tb/timer_tick_tree_test.sv
module timer_tick_tree_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  ext = 2'b00;
  logic [4:0]  tick;

  int compared = 0;
  int mismatched = 0;
  int cur_n[2];
  int cur_k[5];

  timer_tick_tree uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ext_clk_i (ext),
    .tick_o    (tick)
  );

  always #10 clk = ~clk;

  // expected strobe of channel ch in cycle c after the prescale write edge
  function automatic bit exp_tick(int ch, int c);
    int grp = (ch < 2) ? 0 : 1;  // R2
    int k = cur_k[ch];
    int r;
    if (k == 4) begin  // R5: pin 0 rises at c%6==3, pin 1 at c%10==5
      if (grp == 0) return (c >= 5) && (c % 6 == 5);
      else          return (c >= 7) && (c % 10 == 7);
    end
    r = (k < 4) ? (2 << k) : 16;  // R3, R4
    return ((c + 1) % (r * (cur_n[grp] + 1))) == 0;  // R1, R7
  endfunction

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cfg(int n0, int n1, int k0, int k1, int k2, int k3, int k4);
    logic [31:0] d = '0;
    int maxp = 20;
    int win;
    int errs[5];
    int first_c[5];
    bit first_a[5];
    bit first_e[5];
    string tag;
    cur_n[0] = n0; cur_n[1] = n1;
    cur_k[0] = k0; cur_k[1] = k1; cur_k[2] = k2; cur_k[3] = k3; cur_k[4] = k4;
    ext = 2'b00;
    repeat (4) @(negedge clk);
    for (int ch = 0; ch < 5; ch++) begin
      int r = (cur_k[ch] < 4) ? (2 << cur_k[ch]) : 16;
      int p = r * (cur_n[ch < 2 ? 0 : 1] + 1);
      d = d | (32'(cur_k[ch] & 15) << (4 * ch));
      if (cur_k[ch] != 4 && p > maxp) maxp = p;
      errs[ch] = 0; first_c[ch] = 0; first_a[ch] = 0; first_e[ch] = 0;
    end
    win = 2 * maxp + 3;
    wr(1'b1, d);
    wr(1'b0, 32'((n1 << 8) | n0));  // R7: full restart here
    for (int c = 0; c < win; c++) begin
      for (int ch = 0; ch < 5; ch++) begin
        bit e = exp_tick(ch, c);
        if (tick[ch] !== e) begin
          if (errs[ch] == 0) begin
            first_c[ch] = c; first_a[ch] = tick[ch]; first_e[ch] = e;
          end
          errs[ch]++;
        end
      end
      ext[0] = ((c / 3) % 2) == 1;
      ext[1] = ((c / 5) % 2) == 1;
      @(negedge clk);
    end
    for (int ch = 0; ch < 5; ch++) begin
      compared++;
      tag = (cur_k[ch] == 4) ? "R5" : ((cur_k[ch] < 4) ? "R3" : "R4");
      if (errs[ch] != 0) begin
        mismatched++;
        $display("FAIL %s ch%0d n=%0d/%0d code=%0d cycle %0d: actual %0d expected %0d",
                 tag, ch, n0, n1, cur_k[ch], first_c[ch], first_a[ch], first_e[ch]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit bad;
    repeat (3) @(negedge clk);
    compared++;  // R8: quiet in reset
    if (tick !== 5'b0) begin
      mismatched++;
      $display("FAIL R8 in reset: actual %b expected 00000", tick);
    end
    rst_n = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 12; k++) begin  // R8: divide-by-2 default
      if (tick !== ((k % 2 == 1) ? 5'b11111 : 5'b00000)) begin
        if (!bad) $display("FAIL R8 sample %0d: actual %b expected %b",
                           k, tick, (k % 2 == 1) ? 5'b11111 : 5'b00000);
        bad = 1'b1;
      end
      @(negedge clk);
    end
    compared++;
    if (bad) mismatched++;
    // R1 R2 R3 R4 R5 R6 R7: sweep of prescale values, codes and sources
    run_cfg(0, 0, 0, 1, 2, 3, 5);
    run_cfg(1, 2, 3, 2, 1, 0, 15);
    run_cfg(2, 0, 4, 0, 4, 1, 4);
    run_cfg(6, 3, 7, 4, 3, 4, 0);
    run_cfg(3, 6, 1, 3, 8, 2, 4);
    run_cfg(4, 1, 4, 4, 0, 12, 2);
    run_cfg(0, 5, 2, 9, 4, 4, 3);
    run_cfg(0, 255, 1, 0, 0, 4, 0);
    run_cfg(255, 1, 0, 4, 6, 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule